// File: doc/BRIEF.md
# Dual-Bank Mixed-Trigger Interrupt Controller

This block gathers 64 synchronous interrupt request lines into two 32-bit banks and merges them into one interrupt output for a processor. Each bit is either edge-latched or level-sensitive. The choice is fixed per bit by a pattern set at elaboration. An edge-latched bit records a rising input as a sticky event, and the event stays until software clears it. A level-sensitive bit never records an event. It requests service for as long as its input is high.

Each bank keeps three registers: events, an enable mask, and a registered copy of its input levels. A single-cycle 32-bit register bus gives software read access to all three. Software can also write the mask and clear event bits. The output is high while any enabled bit in either bank has a pending event or is a high level-sensitive input.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: Input lines 0..31 map to bank 1 bit n, and input lines 32..63 map to bank 0 bit (n-32).
- R2: For a bit that is not level-sensitive, a rising input sets its event bit at the next clock edge. A line held high does not set the event again after software has cleared it.
- R3: The levels register equals the input lines as sampled at the previous clock edge. A falling input clears only the levels bit, and an event that was already set stays set.
- R4: Level-sensitive bits never set an event. Bank 1 is level-sensitive on bits 20..28 (pattern 0x1FF00000), and bank 0 has no level-sensitive bits. A high, enabled level-sensitive input holds irq_out high, and the request drops when the input falls.
- R5: irq_out is combinational from the registers. It is high exactly when, for some bank, ((events | (levels & level_pattern)) & mask) is nonzero.
- R6: Bank 0 is at address 0x010 and bank 1 is at address 0x020. The offsets within a bank are 0x0 for events (read), 0x4 for mask (read and write), 0x8 for event clear (write only) and 0xC for levels (read). rd_data is valid in the same cycle as rd_en, and it is zero while rd_en is low.
- R7: Bank select is ((addr - 0x010) >> 4), computed modulo 2^12. Any address whose bank select is not 0 or 1 reads as zero and ignores writes. So does any other offset, including a write to 0x0 or 0xC.
- R8: A write to the clear offset clears every event bit where wr_data is 1. Level-sensitive bits are excluded, so their requests persist.
- R9: If a rising input and a clear hit the same event bit in the same cycle, the event is set.
- R10: Synchronous active-high reset zeroes events, mask and levels in both banks, and irq_out is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Synchronous interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when not reading |
| irq_out | output | 1 | Combined processor interrupt |

## Verification
The hardest case to reach is a rising input on a bit landing in the same cycle as a software clear of that bit. The stimulus must raise the line and issue the clear write together, and that only happens with both driven in one cycle. A directed case does exactly that, and the random phase toggles sparse input bits while it issues clears, which produces further collisions. A held-high line that is cleared and must not re-latch also needs its own directed sequence. Random input toggling rarely holds a line steady across a clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BW         = 32;
    localparam int NBANK      = 2;
    localparam int BIDX_W     = $clog2(NBANK);
    localparam int ADDR_W     = 12;
    localparam int OFS_W      = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_EVENTS = 4'h0,
        OFS_MASK   = 4'h4,
        OFS_CLEAR  = 4'h8,
        OFS_LEVELS = 4'hC
    } reg_ofs_e;

    typedef struct packed {
        logic              hit;
        logic [BIDX_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
    } dec_t;

    typedef struct packed {
        logic [BW-1:0] events;
        logic [BW-1:0] mask;
        logic [BW-1:0] levels;
    } bank_view_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned BASE   = 16,
    parameter int unsigned STRIDE = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int SH = $clog2(STRIDE);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        rel      = addr - ADDR_W'(BASE);
        idx      = rel >> SH;
        dec.hit  = (idx < ADDR_W'(NBANK));
        dec.bank = idx[BIDX_W-1:0];
        dec.ofs  = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BW-1:0] LVL_TRIG = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] lines,
    input  logic          mask_we,
    input  logic [BW-1:0] mask_wd,
    input  logic          clr_we,
    input  logic [BW-1:0] clr_wd,
    output bank_view_t    view,
    output logic          req
);
    logic [BW-1:0] ev_q, mask_q, lvl_q;
    logic [BW-1:0] rise, set_bits, clr_bits;

    always_comb begin
        rise     = lines & ~lvl_q;
        set_bits = rise & ~LVL_TRIG;
        clr_bits = clr_we ? (clr_wd & ~LVL_TRIG) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q   <= '0;
            mask_q <= '0;
            lvl_q  <= '0;
        end else begin
            lvl_q <= lines;
            ev_q  <= (ev_q & ~clr_bits) | set_bits;
            if (mask_we) mask_q <= mask_wd;
        end
    end

    assign view.events = ev_q;
    assign view.mask   = mask_q;
    assign view.levels = lvl_q;
    assign req         = |((ev_q | (lvl_q & LVL_TRIG)) & mask_q);

    AST_LT_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (ev_q & LVL_TRIG) == '0);                                        // R4
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        !rst |=> lvl_q == $past(lines));                                 // R3
    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> (ev_q & $past(ev_q)) == $past(ev_q));                // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (ev_q & $past(set_bits)) == $past(set_bits));           // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));                                   // R6
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
    import irqc_pkg::*;
#(
    parameter logic [BW-1:0] LVL_TRIG_B0 = 32'h0000_0000,
    parameter logic [BW-1:0] LVL_TRIG_B1 = 32'h1FF0_0000,
    parameter int unsigned   BANK_BASE   = 16,
    parameter int unsigned   BANK_STRIDE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NBANK*BW-1:0] irq_in,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BW-1:0]       wr_data,
    output logic [BW-1:0]       rd_data,
    output logic                irq_out
);
    dec_t               dec;
    bank_view_t         views [NBANK];
    logic [NBANK-1:0]   bank_req;

    irqc_decode #(.BASE(BANK_BASE), .STRIDE(BANK_STRIDE)) i_dec (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [BW-1:0] LT = (b == 1) ? LVL_TRIG_B1 : LVL_TRIG_B0;
        logic sel;
        assign sel = wr_en && dec.hit && (dec.bank == BIDX_W'(b));

        irqc_bank #(.LVL_TRIG(LT)) i_bank (
            .clk     (clk),
            .rst     (rst),
            .lines   (irq_in[(NBANK-1-b)*BW +: BW]),
            .mask_we (sel && dec.ofs == OFS_MASK),
            .mask_wd (wr_data),
            .clr_we  (sel && dec.ofs == OFS_CLEAR),
            .clr_wd  (wr_data),
            .view    (views[b]),
            .req     (bank_req[b])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_en && dec.hit) begin
            case (dec.ofs)
                OFS_EVENTS: rd_data = views[dec.bank].events;
                OFS_MASK:   rd_data = views[dec.bank].mask;
                OFS_LEVELS: rd_data = views[dec.bank].levels;
                default:    rd_data = '0;
            endcase
        end
    end

    assign irq_out = |bank_req;

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);                                       // R6
    AST_RD_LOW_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr < ADDR_W'(BANK_BASE)) |-> rd_data == '0);         // R7
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (views[0].mask == '0 && views[1].mask == '0) |-> !irq_out);      // R5
endmodule

// File: tb/test_dual_bank_irq_ctrl.sv
module test_dual_bank_irq_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst;
    logic [63:0] irq_in;
    logic        wr_en, rd_en;
    logic [11:0] addr;
    logic [31:0] wr_data, rd_data;
    logic        irq_out;

    int n_chk = 0, n_fail = 0;

    logic [31:0] m_ev [2];
    logic [31:0] m_mk [2];
    logic [31:0] m_lv [2];
    logic [31:0] lt   [2];
    logic [63:0] cur_in;

    always #(CLK_P/2) clk = ~clk;

    dual_bank_irq_ctrl i_dual_bank_irq_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bank_in(int b, logic [63:0] v);
        return (b == 0) ? v[63:32] : v[31:0];
    endfunction

    function automatic int bank_of(logic [11:0] a);
        logic [11:0] rel;
        rel = a - 12'h010;
        rel = rel >> 4;
        return (rel < 12'd2) ? int'(rel) : -1;
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        int b;
        b = bank_of(a);
        if (b < 0) return 32'h0;
        case (a[3:0])
            4'h0: return m_ev[b];
            4'h4: return m_mk[b];
            4'hC: return m_lv[b];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 1'b0;
        for (int b = 0; b < 2; b++)
            if (((m_ev[b] | (m_lv[b] & lt[b])) & m_mk[b]) != 0) r = 1'b1;
        return r;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            m_ev[b] = 0; m_mk[b] = 0; m_lv[b] = 0;
        end
    endtask

    task automatic do_cycle(logic [63:0] in, logic we, logic re, logic [11:0] a,
                            logic [31:0] wd, string tag, logic xchk, logic [31:0] xexp);
        int b;
        logic [31:0] nin, rise, clr;
        @(negedge clk);
        irq_in = in; wr_en = we; rd_en = re; addr = a; wr_data = wd;
        #(CLK_P/4);
        chk("R5 irq_out", {31'h0, irq_out}, {31'h0, exp_irq()});
        if (re) begin
            chk(bank_of(a) >= 0 ? "R6 read" : "R7 read", rd_data, exp_rd(a));
            if (xchk) chk(tag, rd_data, xexp);
        end
        @(posedge clk);
        b = bank_of(a);
        for (int k = 0; k < 2; k++) begin
            nin  = bank_in(k, in);
            rise = nin & ~m_lv[k] & ~lt[k];
            clr  = (we && b == k && a[3:0] == 4'h8) ? (wd & ~lt[k]) : 32'h0;
            m_ev[k] = (m_ev[k] & ~clr) | rise;
            if (we && b == k && a[3:0] == 4'h4) m_mk[k] = wd;
            m_lv[k] = nin;
        end
        #1;
        wr_en = 0; rd_en = 0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        do_cycle(cur_in, 1'b0, 1'b1, a, 32'h0, tag, 1'b1, e);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        do_cycle(cur_in, 1'b1, 1'b0, a, d, "", 1'b0, 32'h0);
    endtask

    task automatic step();
        do_cycle(cur_in, 1'b0, 1'b0, 12'h0, 32'h0, "", 1'b0, 32'h0);
    endtask

    task automatic irq_is(logic e, string tag);
        @(negedge clk); #(CLK_P/4);
        chk(tag, {31'h0, irq_out}, {31'h0, e});
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        lt[0] = 32'h0; lt[1] = 32'h1FF0_0000;
        cur_in = 0; irq_in = 0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk); rst = 0;

        // R10 reset state
        rd(12'h010, 0, "R10 ev0"); rd(12'h014, 0, "R10 mk0"); rd(12'h01C, 0, "R10 lv0");
        rd(12'h020, 0, "R10 ev1"); rd(12'h024, 0, "R10 mk1"); rd(12'h02C, 0, "R10 lv1");
        irq_is(1'b0, "R10 irq");

        // R1 bank mapping
        cur_in[5] = 1; cur_in[40] = 1; step();
        rd(12'h020, 32'h20, "R1 line5 bank1");
        rd(12'h010, 32'h100, "R1 line40 bank0");
        rd(12'h01C, 32'h100, "R3 levels bank0");
        irq_is(1'b0, "R5 masked");
        wr(12'h024, 32'h20);
        irq_is(1'b1, "R5 enabled");

        // R2 clear with line held high
        wr(12'h028, 32'h20);
        rd(12'h020, 32'h0, "R2 no relatch");
        irq_is(1'b0, "R2 irq low");

        // R3 deassert keeps event
        cur_in[40] = 0; step();
        rd(12'h010, 32'h100, "R3 sticky event");
        rd(12'h01C, 32'h0, "R3 level cleared");

        // R4 level-sensitive bit 22 of bank 1
        cur_in[22] = 1; step();
        rd(12'h020, 32'h0, "R4 no event");
        rd(12'h02C, 32'h0040_0020, "R4 levels");
        wr(12'h024, 32'h0040_0000);
        irq_is(1'b1, "R4 level irq");
        wr(12'h028, 32'hFFFF_FFFF);
        irq_is(1'b1, "R8 level survives clear");
        cur_in[22] = 0; step();
        irq_is(1'b0, "R4 level drop");

        // R8 clear of a latched event
        wr(12'h018, 32'h100);
        rd(12'h010, 32'h0, "R8 cleared");

        // R9 set wins over clear
        cur_in[3] = 1;
        do_cycle(cur_in, 1'b1, 1'b0, 12'h028, 32'h8, "", 1'b0, 32'h0);
        rd(12'h020, 32'h8, "R9 set wins");

        // R7 decode misses
        wr(12'h034, 32'hFFFF_FFFF);
        rd(12'h014, 32'h0, "R7 bank2 write ignored");
        rd(12'h024, 32'h0040_0000, "R7 bank1 mask kept");
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, 32'h8, "R7 event write ignored");
        rd(12'h008, 32'h0, "R7 low addr");
        rd(12'h018, 32'h0, "R7 clear offset reads 0");
        rd(12'h034, 32'h0, "R7 bank2 read");
        rd(12'hF24, 32'h0, "R7 high addr");

        // R6 idle read bus
        @(negedge clk); #(CLK_P/4);
        chk("R6 idle rd_data", rd_data, 32'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [11:0] a;
            logic [31:0] d;
            op = int'($urandom % 8);
            cur_in ^= {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            d = $urandom;
            case (op)
                3, 4: begin
                    a = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 64);
                    do_cycle(cur_in, 1'b0, 1'b1, a, 0, "", 1'b0, 0);
                end
                5: do_cycle(cur_in, 1'b1, 1'b0, ($urandom % 2) ? 12'h014 : 12'h024, d, "", 1'b0, 0);
                6: do_cycle(cur_in, 1'b1, 1'b0, ($urandom % 2) ? 12'h018 : 12'h028, d, "", 1'b0, 0);
                7: do_cycle(cur_in, 1'b1, 1'b1, 12'($urandom % 64), d, "", 1'b0, 0);
                default: step();
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule